// File: doc/BRIEF.md
# Processor Debug Register Target

This block is the slave end of a debug request channel on a simple processor core. An external host issues single-word reads and writes over a four-bit address space. The block answers each one with a single acknowledge pulse, and read data is valid in that same cycle. Through this address space the host can freeze the core, advance it by one instruction at a time and release it again. It can also inspect the core's architectural state while the core is frozen.

On the core side the block drives a level that holds the core stopped and a one-cycle step pulse, and it watches a stopped-status input. It reads the core's next-instruction address, machine state word, condition register, fixed-point exception flags and, through an index it stores itself, any entry of the 32-entry general-purpose register file.

Top module: `dbg_target`

## Requirements
- R1: An access starts when `dbgReq` is high while the block is armed. `dbgAck` rises for exactly one cycle on the next clock edge. The block disarms on acceptance and re-arms only after sampling `dbgReq` low, so a request held high produces no second acknowledge.
- R2: After reset `coreHalt`, `coreStep` and `dbgAck` are low, the stored index is zero (so `gprIdx` is 0), and the block is armed.
- R3: A write to address 0 with data bit 0 set raises `coreHalt`. A write to address 0 with bit 1 set (and bit 0 clear) lowers it. When both bits are set, halt wins. `coreHalt` changes in the acknowledge cycle.
- R4: A write to address 0 with data bit 3 set pulses `coreStep` high for one cycle, coincident with the acknowledge. This happens only if `coreStopped` was high when the request was accepted; otherwise there is no pulse.
- R5: A read of address 0 returns the halt hold in bit 0. A read of address 1 returns `coreStopped` in bit 1 (value 2) and the halt hold in bit 0. All other bits of both words are zero.
- R6: Reads of address 2, 3 and 8 return `corePc`, `coreMsr` and `coreCr`, sampled at acceptance.
- R7: A write to address 4 stores the low 8 bits of the write data as the register index. A read of address 4 returns that index zero-extended. `gprIdx` carries its low 5 bits.
- R8: A read of address 5 returns `gprData` when the stored index is below 32, and zero otherwise.
- R9: A read of address 9 maps `coreXer` input bits 0 to 4 (summary overflow, carry, carry-32, overflow, overflow-32) onto readout bits 0, 2, 3, 4 and 5. All other readout bits are zero.
- R10: Reads of addresses 6, 7 and 10 to 15 return zero and are acknowledged. Writes to any address other than 0 and 4 are acknowledged and change no state. Every write acknowledge carries zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbgReq | input | 1 | Host request |
| dbgWe | input | 1 | High for write, low for read |
| dbgAddr | input | 4 | Debug register address |
| dbgWdata | input | 64 | Write data |
| dbgRdata | output | 64 | Read data, valid with acknowledge |
| dbgAck | output | 1 | One-cycle acknowledge |
| coreHalt | output | 1 | Holds the core stopped |
| coreStep | output | 1 | One-cycle single-step pulse |
| coreStopped | input | 1 | Core reports it is stopped |
| corePc | input | 64 | Next-instruction address |
| coreMsr | input | 64 | Machine state word |
| coreCr | input | 64 | Condition register |
| coreXer | input | 5 | Exception flags {ov32, ov, ca32, ca, so} |
| gprIdx | output | 5 | Register-file read index |
| gprData | input | 64 | Register-file read data for `gprIdx` |

## Verification
The assertions assume the host follows the handshake. It keeps `dbgReq`, `dbgWe`, `dbgAddr` and `dbgWdata` stable from the request until the acknowledge, so the values seen one cycle before an acknowledge are those of the accepted access. The stimulus tasks raise a request, hold every field until the acknowledge, sometimes keep the request high for extra cycles to probe the re-arm rule, then drop it and idle a cycle. The state inputs only change while no request is pending.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_STAT = 1;
  localparam int unsigned ADR_PC   = 2;
  localparam int unsigned ADR_MSR  = 3;
  localparam int unsigned ADR_IDX  = 4;
  localparam int unsigned ADR_GPR  = 5;
  localparam int unsigned ADR_CR   = 8;
  localparam int unsigned ADR_XER  = 9;

  localparam int unsigned CTL_HALT   = 0;
  localparam int unsigned CTL_RESUME = 1;
  localparam int unsigned CTL_STEP   = 3;
  localparam int unsigned STAT_STOP  = 1;

  typedef enum logic [3:0] {
    RD_NONE, RD_CTRL, RD_STAT, RD_PC, RD_MSR, RD_IDX, RD_GPR, RD_CR, RD_XER
  } rd_sel_e;

  typedef struct packed {
    logic    load;
    logic    ldIdx;
    logic    setHalt;
    logic    clrHalt;
    logic    pulseStep;
    rd_sel_e rdSel;
  } dbg_strobe_t;
endpackage

// File: rtl/dbg_ctrl.sv
module dbg_ctrl
  import dbg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbgReq,
  input  logic              dbgWe,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic [DATA_W-1:0] dbgWdata,
  input  logic              coreStopped,
  output dbg_strobe_t       strb
);
  logic armed;
  logic accept;
  logic isCtrlWr;

  assign accept   = dbgReq && armed;
  assign isCtrlWr = accept && dbgWe && (dbgAddr == ADDR_W'(ADR_CTRL));

  // armed drops on acceptance and returns once request is seen low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b1;
    else if (accept)   armed <= 1'b0;
    else if (!dbgReq)  armed <= 1'b1;
  end

  always_comb begin
    strb.load      = accept;
    strb.ldIdx     = accept && dbgWe && (dbgAddr == ADDR_W'(ADR_IDX));
    strb.setHalt   = isCtrlWr && dbgWdata[CTL_HALT];
    strb.clrHalt   = isCtrlWr && dbgWdata[CTL_RESUME];
    strb.pulseStep = isCtrlWr && dbgWdata[CTL_STEP] && coreStopped;
    strb.rdSel     = RD_NONE;
    if (accept && !dbgWe) begin
      case (dbgAddr)
        ADDR_W'(ADR_CTRL): strb.rdSel = RD_CTRL;
        ADDR_W'(ADR_STAT): strb.rdSel = RD_STAT;
        ADDR_W'(ADR_PC):   strb.rdSel = RD_PC;
        ADDR_W'(ADR_MSR):  strb.rdSel = RD_MSR;
        ADDR_W'(ADR_IDX):  strb.rdSel = RD_IDX;
        ADDR_W'(ADR_GPR):  strb.rdSel = RD_GPR;
        ADDR_W'(ADR_CR):   strb.rdSel = RD_CR;
        ADDR_W'(ADR_XER):  strb.rdSel = RD_XER;
        default:           strb.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dbg_datapath.sv
module dbg_datapath
  import dbg_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned GPR_COUNT = 32,
  parameter int unsigned XER_W     = 5,
  localparam int unsigned SEL_W    = $clog2(GPR_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dbg_strobe_t       strb,
  input  logic [DATA_W-1:0] dbgWdata,
  input  logic              coreStopped,
  input  logic [DATA_W-1:0] corePc,
  input  logic [DATA_W-1:0] coreMsr,
  input  logic [DATA_W-1:0] coreCr,
  input  logic [XER_W-1:0]  coreXer,
  input  logic [DATA_W-1:0] gprData,
  output logic [SEL_W-1:0]  gprIdx,
  output logic [DATA_W-1:0] dbgRdata,
  output logic              dbgAck,
  output logic              coreHalt,
  output logic              coreStep
);
  // readout bit for each exception flag: so, ca, ca32, ov, ov32
  localparam int unsigned XER_POS [XER_W] = '{0, 2, 3, 4, 5};

  logic [IDX_W-1:0]  idxReg;
  logic              idxInRange;
  logic [DATA_W-1:0] xerWord;
  logic [DATA_W-1:0] rdNext;

  assign idxInRange = (idxReg < IDX_W'(GPR_COUNT));
  assign gprIdx     = idxReg[SEL_W-1:0];

  always_comb begin
    xerWord = '0;
    for (int i = 0; i < XER_W; i++) xerWord[XER_POS[i]] = coreXer[i];
  end

  always_comb begin
    rdNext = '0;
    case (strb.rdSel)
      RD_CTRL: rdNext[CTL_HALT] = coreHalt;
      RD_STAT: begin
        rdNext[STAT_STOP] = coreStopped;
        rdNext[CTL_HALT]  = coreHalt;
      end
      RD_PC:   rdNext = corePc;
      RD_MSR:  rdNext = coreMsr;
      RD_IDX:  rdNext = DATA_W'(idxReg);
      RD_GPR:  rdNext = idxInRange ? gprData : '0;
      RD_CR:   rdNext = coreCr;
      RD_XER:  rdNext = xerWord;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idxReg   <= '0;
      coreHalt <= 1'b0;
      coreStep <= 1'b0;
      dbgAck   <= 1'b0;
      dbgRdata <= '0;
    end else begin
      dbgAck   <= strb.load;
      coreStep <= strb.pulseStep;
      if (strb.ldIdx)        idxReg   <= dbgWdata[IDX_W-1:0];
      if (strb.setHalt)      coreHalt <= 1'b1;
      else if (strb.clrHalt) coreHalt <= 1'b0;
      if (strb.load)         dbgRdata <= rdNext;
    end
  end
endmodule

// File: rtl/dbg_target.sv
module dbg_target
  import dbg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned GPR_COUNT = 32,
  parameter int unsigned XER_W     = 5,
  localparam int unsigned SEL_W    = $clog2(GPR_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbgReq,
  input  logic              dbgWe,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic [DATA_W-1:0] dbgWdata,
  output logic [DATA_W-1:0] dbgRdata,
  output logic              dbgAck,
  output logic              coreHalt,
  output logic              coreStep,
  input  logic              coreStopped,
  input  logic [DATA_W-1:0] corePc,
  input  logic [DATA_W-1:0] coreMsr,
  input  logic [DATA_W-1:0] coreCr,
  input  logic [XER_W-1:0]  coreXer,
  output logic [SEL_W-1:0]  gprIdx,
  input  logic [DATA_W-1:0] gprData
);
  dbg_strobe_t strb;

  dbg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .dbgReq(dbgReq), .dbgWe(dbgWe),
    .dbgAddr(dbgAddr), .dbgWdata(dbgWdata), .coreStopped(coreStopped),
    .strb(strb)
  );

  dbg_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W), .GPR_COUNT(GPR_COUNT),
                 .XER_W(XER_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .dbgWdata(dbgWdata),
    .coreStopped(coreStopped), .corePc(corePc), .coreMsr(coreMsr),
    .coreCr(coreCr), .coreXer(coreXer), .gprData(gprData),
    .gprIdx(gprIdx), .dbgRdata(dbgRdata), .dbgAck(dbgAck),
    .coreHalt(coreHalt), .coreStep(coreStep)
  );
endmodule

// File: rtl/dbg_target_chk.sv
module dbg_target_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbgReq,
  input logic              dbgWe,
  input logic [ADDR_W-1:0] dbgAddr,
  input logic [DATA_W-1:0] dbgWdata,
  input logic [DATA_W-1:0] dbgRdata,
  input logic              dbgAck,
  input logic              coreHalt,
  input logic              coreStep,
  input logic              coreStopped
);
  logic unmapped;
  assign unmapped = (dbgAddr == 4'd6) || (dbgAddr == 4'd7) || (dbgAddr >= 4'd10);

  // R1: acknowledge is a single-cycle pulse answering a request
  a_r1_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dbgAck |=> !dbgAck);
  a_r1_ack_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbgAck) |-> $past(dbgReq));

  // R3: halt write raises the hold by the acknowledge
  a_r3_halt_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dbgReq && dbgWe && dbgAddr == 4'd0 && dbgWdata[0] && !dbgAck)
      |=> (dbgAck -> coreHalt));

  // R4: step pulse only with an acknowledge, and only one cycle wide
  a_r4_step_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    coreStep |-> dbgAck);
  a_r4_step_single: assert property (@(posedge clk) disable iff (!rst_n)
    coreStep |=> !coreStep);

  // R10: unmapped reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dbgReq && !dbgWe && unmapped && !dbgAck) |=> (dbgAck -> dbgRdata == '0));
endmodule

bind dbg_target dbg_target_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbgReq(dbgReq), .dbgWe(dbgWe),
  .dbgAddr(dbgAddr), .dbgWdata(dbgWdata), .dbgRdata(dbgRdata),
  .dbgAck(dbgAck), .coreHalt(coreHalt), .coreStep(coreStep),
  .coreStopped(coreStopped)
);

// File: tb/tb_dbg_target.sv
module tb_dbg_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbgReq = 1'b0, dbgWe = 1'b0;
  logic [3:0]  dbgAddr = '0;
  logic [63:0] dbgWdata = '0;
  logic [63:0] dbgRdata;
  logic        dbgAck, coreHalt, coreStep;
  logic        coreStopped = 1'b0;
  logic [63:0] corePc = 64'h0000_0000_0000_1000;
  logic [63:0] coreMsr = 64'h8000_0000_0000_0001;
  logic [63:0] coreCr = 64'h0000_0000_2468_ACE0;
  logic [4:0]  coreXer = '0;
  logic [4:0]  gprIdx;
  logic [63:0] gprData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [63:0] gprVal(int i);
    return 64'hC0DE_0000_0000_0000 + 64'(i) * 7;
  endfunction
  assign gprData = gprVal(int'(gprIdx));

  dbg_target dut (
    .clk(clk), .rst_n(rst_n), .dbgReq(dbgReq), .dbgWe(dbgWe),
    .dbgAddr(dbgAddr), .dbgWdata(dbgWdata), .dbgRdata(dbgRdata),
    .dbgAck(dbgAck), .coreHalt(coreHalt), .coreStep(coreStep),
    .coreStopped(coreStopped), .corePc(corePc), .coreMsr(coreMsr),
    .coreCr(coreCr), .coreXer(coreXer), .gprIdx(gprIdx), .gprData(gprData)
  );

  // behavioural reference model
  bit          mArmed = 1;
  bit          mAck = 0, mHalt = 0, mStep = 0;
  int          mIdx = 0;
  logic [63:0] mData = '0;
  string       mTag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      mArmed = 1; mAck = 0; mHalt = 0; mStep = 0; mIdx = 0; mData = '0;
    end else begin
      mAck = 0; mStep = 0;
      if (dbgReq && mArmed) begin
        mArmed = 0; mAck = 1; mData = '0; mTag = "R10";
        if (dbgWe) begin
          if (dbgAddr == 0) begin
            if (dbgWdata[0]) mHalt = 1;
            else if (dbgWdata[1]) mHalt = 0;
            if (dbgWdata[3] && coreStopped) mStep = 1;
          end else if (dbgAddr == 4) mIdx = int'(dbgWdata[7:0]);
        end else begin
          case (int'(dbgAddr))
            0: begin mData = {63'd0, mHalt}; mTag = "R5"; end
            1: begin mData = {62'd0, coreStopped, mHalt}; mTag = "R5"; end
            2: begin mData = corePc; mTag = "R6"; end
            3: begin mData = coreMsr; mTag = "R6"; end
            4: begin mData = 64'(mIdx); mTag = "R7"; end
            5: begin mData = (mIdx < 32) ? gprVal(mIdx) : 64'd0; mTag = "R8"; end
            8: begin mData = coreCr; mTag = "R6"; end
            9: begin
              mData = '0;
              mData[0] = coreXer[0]; mData[2] = coreXer[1]; mData[3] = coreXer[2];
              mData[4] = coreXer[3]; mData[5] = coreXer[4]; mTag = "R9";
            end
            default: begin mData = '0; mTag = "R10"; end
          endcase
        end
      end else if (!dbgReq) mArmed = 1;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // compare every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R1 ack", 64'(dbgAck), 64'(mAck));
      check("R3 halt", 64'(coreHalt), 64'(mHalt));
      check("R4 step", 64'(coreStep), 64'(mStep));
      check("R7 gprIdx", 64'(gprIdx), 64'(mIdx % 32));
      if (mAck) check(mTag, dbgRdata, mData);
    end
  end

  task automatic access(bit we, int adr, logic [63:0] wd, int hold);
    int n = 0;
    @(negedge clk);
    dbgReq = 1; dbgWe = we; dbgAddr = 4'(adr); dbgWdata = wd;
    do begin @(negedge clk); n++; end while (!dbgAck && n < 20);
    if (n >= 20) check("R1 timeout", 64'(1), 64'(0));
    repeat (hold) @(negedge clk);
    dbgReq = 0; dbgWe = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 ack", 64'(dbgAck), 64'd0);
    check("R2 halt", 64'(coreHalt), 64'd0);
    check("R2 step", 64'(coreStep), 64'd0);
    check("R2 idx", 64'(gprIdx), 64'd0);
    rst_n = 1;
    access(0, 1, 0, 0);                    // R5 status running
    access(1, 0, 64'h1, 0);                // R3 halt
    coreStopped = 1;
    access(0, 1, 0, 3);                    // R5 + R1 held request
    access(0, 0, 0, 0);                    // R5 control readback
    access(1, 0, 64'h8, 0);                // R4 step while stopped
    coreStopped = 0;
    access(1, 0, 64'h8, 2);                // R4 step ignored
    access(1, 0, 64'h2, 0);                // R3 resume
    access(1, 0, 64'h3, 0);                // R3 both: halt wins
    access(1, 0, 64'h2, 0);
    access(0, 2, 0, 0);
    access(0, 3, 0, 0);
    access(0, 8, 0, 0);                    // R6
    corePc = 64'hFFFF_0000_1234_5678; coreCr = '1;
    access(0, 2, 0, 0);
    access(0, 8, 0, 0);
    for (int x = 0; x < 32; x += 5) begin  // R9
      coreXer = 5'(x);
      access(0, 9, 0, 0);
    end
    coreXer = 5'h1F; access(0, 9, 0, 0);
    access(1, 4, 64'd3, 0);   access(0, 4, 0, 0); access(0, 5, 0, 0);  // R7 R8
    access(1, 4, 64'd31, 0);  access(0, 5, 0, 0);
    access(1, 4, 64'd32, 0);  access(0, 5, 0, 0); access(0, 4, 0, 0);
    access(1, 4, 64'd255, 0); access(0, 5, 0, 0);
    access(1, 4, 64'h1_0000_0102, 0); access(0, 4, 0, 0); access(0, 5, 0, 0);
    for (int a = 6; a < 16; a++) if (a != 8 && a != 9) access(0, a, 0, 0); // R10
    access(1, 2, 64'hDEAD, 0); access(1, 1, 64'h1, 0); access(1, 5, 64'h9, 0);
    access(1, 12, 64'h9, 0);
    access(0, 0, 0, 0); access(0, 4, 0, 0); access(0, 2, 0, 0);
    repeat (4) @(negedge clk);
    done = 1;
  end

  initial begin
    while (!done && cycles < 20000) begin @(posedge clk); cycles++; end
    if (!done) check("R1 watchdog", 64'(1), 64'(0));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule